// File: doc/BRIEF.md
# Pipeline Hazard Stall Controller

This block decides, cycle by cycle, which stages of a short in-order 32-bit pipeline must hold, where no-op bubbles go, and from which later stage each decode operand should be taken. It looks at the register addresses of the instruction in decode and of the results in the execute and memory stages. It also watches a taken-branch strobe with a delay-slot flag, a busy flag from a multi-cycle execute unit, and the request/ready pair of the data memory.

Data hazards are mostly removed by forwarding. The execute-stage result has priority over the memory-stage result, because it is younger. Register 0 is never a source of a dependency. A value loaded by the instruction in execute cannot be forwarded in time, so decode is interlocked for as long as that load sits in execute. In a flowing pipeline that is exactly one cycle. A taken branch stalls fetch for a fixed penalty while the target is fetched. A delay-slot branch lets the following instruction run and costs one cycle less. The branch penalty counter keeps running while other hazards stall the pipeline. As a result, hazards that overlap cost the longest of them, not their sum.

Stall outputs are nested: a held stage always holds every earlier stage too. The stage directly after the oldest held stage receives a bubble.

Top module: `hazard_stall_unit`

## Requirements
- R1: After reset, with no valid producer in execute or memory, no taken branch, execute idle and no memory request, every stall and bubble output is 0 and both forward selects are 0.
- R2: For each operand, if the execute stage is valid, writes, and its destination equals the nonzero operand address, the select is 1 (execute result), whether or not the memory stage also matches.
- R3: For each operand without an execute match, a valid writing memory stage with the same nonzero destination gives select 2 (memory result); otherwise the select is 0 (register file).
- R4: An operand address of 0 never yields a nonzero forward select and never causes an interlock.
- R5: When the execute stage holds a valid writing load whose destination matches a used nonzero decode operand, stallDecode and stallFetch are 1 and bubbleExecute is 1, provided execute is not itself held.
- R6: While execBusy is 1, fetch, decode and execute are held and bubbleMemory is 1, unless the memory stage is waiting.
- R7: While memReq is 1 and memReady is 0, all four stages are held, bubbleWriteback is 1 and no other bubble is raised.
- R8: A taken branch without a delay slot makes stallFetch 1 for BR_PENALTY cycles, starting in the cycle after the strobe. fetchBubble is 1 in each of those cycles in which decode is not held.
- R9: A taken branch with the delay slot flag set stalls fetch for BR_PENALTY-1 cycles under the same rule.
- R10: When a branch penalty overlaps a memory wait or execute busy period that starts in the same cycle, stallFetch lasts max(wait length, penalty) cycles, and fetchBubble is raised for the penalty cycles not covered by the other stall.
- R11: A held memory stage implies held execute; held execute implies held decode; held decode implies held fetch. At most one of the four bubble outputs is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| decRs1 | input | REG_ADDR_W | First source register of the decode instruction |
| decRs2 | input | REG_ADDR_W | Second source register of the decode instruction |
| decUseRs1 | input | 1 | Decode instruction reads decRs1 |
| decUseRs2 | input | 1 | Decode instruction reads decRs2 |
| exRd | input | REG_ADDR_W | Destination register in execute |
| exWe | input | 1 | Execute instruction writes a register |
| exIsLoad | input | 1 | Execute instruction is a load |
| exValid | input | 1 | Execute stage holds a real instruction |
| memRd | input | REG_ADDR_W | Destination register in the memory stage |
| memWe | input | 1 | Memory-stage instruction writes a register |
| memValid | input | 1 | Memory stage holds a real instruction |
| brTaken | input | 1 | One-cycle strobe: a branch was taken |
| brDelaySlot | input | 1 | The taken branch has a delay slot |
| execBusy | input | 1 | Multi-cycle execute operation not finished |
| memReq | input | 1 | Data memory access in progress |
| memReady | input | 1 | Data memory access completes this cycle |
| stallFetch | output | 1 | Hold the fetch stage |
| stallDecode | output | 1 | Hold the decode stage |
| stallExecute | output | 1 | Hold the execute stage |
| stallMemory | output | 1 | Hold the memory stage |
| bubbleExecute | output | 1 | Load a no-op into execute |
| bubbleMemory | output | 1 | Load a no-op into the memory stage |
| bubbleWriteback | output | 1 | Load a no-op into writeback |
| fetchBubble | output | 1 | Load a no-op into decode while the branch target is pending |
| fwdSelA | output | 2 | Operand 1 source: 0 register file, 1 execute, 2 memory |
| fwdSelB | output | 2 | Operand 2 source: 0 register file, 1 execute, 2 memory |

## Verification
The forwarding and interlock logic is swept over every combination of a four-register address space, with all valid, write, load and use flags. This separates execute-over-memory priority, memory-only matches, register-0 sources and load-use from plain forwardable results. All sixteen mixes of load-use, execute busy, memory request and memory ready are applied to show how the stall and bubble outputs nest. Branches with and without a delay slot are combined with memory waits and execute busy periods of zero to four cycles. Stall lengths that add up would give different counts from lengths that overlap, so these runs show whether the combined stall equals the longest hazard.

// File: rtl/hazard_stall_pkg.sv
package hazard_stall_pkg;

  localparam int NUM_SRC = 2;

  typedef enum logic [1:0] {
    FWD_NONE = 2'd0,
    FWD_EX   = 2'd1,
    FWD_MEM  = 2'd2
  } fwdSel_e;

  // strobes from the operand comparators to the stall control
  typedef struct packed {
    logic [NUM_SRC-1:0] loadUseSrc;
  } hazStrobe_t;

endpackage

// File: rtl/hazard_operand_cmp.sv
module hazard_operand_cmp
  import hazard_stall_pkg::*;
#(
  parameter int REG_ADDR_W = 5
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic [NUM_SRC-1:0][REG_ADDR_W-1:0] srcAddr,
  input  logic [NUM_SRC-1:0]                 srcUsed,
  input  logic [REG_ADDR_W-1:0]              exRd,
  input  logic                               exWe,
  input  logic                               exIsLoad,
  input  logic                               exValid,
  input  logic [REG_ADDR_W-1:0]              memRd,
  input  logic                               memWe,
  input  logic                               memValid,
  output logic [NUM_SRC-1:0][1:0]            fwdSel,
  output hazStrobe_t                         strobe
);

  logic [NUM_SRC-1:0] loadUseVec;
  logic               exProducer;
  logic               memProducer;

  assign exProducer  = exValid & exWe;
  assign memProducer = memValid & memWe;

  for (genvar g = 0; g < NUM_SRC; g++) begin : gSrc
    logic srcLive;
    logic exHit;
    logic memHit;

    assign srcLive = (srcAddr[g] != '0);
    assign exHit   = srcLive & exProducer & (exRd == srcAddr[g]);
    assign memHit  = srcLive & memProducer & (memRd == srcAddr[g]);

    // youngest producer wins
    always_comb begin
      if (exHit)       fwdSel[g] = FWD_EX;
      else if (memHit) fwdSel[g] = FWD_MEM;
      else             fwdSel[g] = FWD_NONE;
    end

    assign loadUseVec[g] = exHit & exIsLoad & srcUsed[g];

    assert_zero_src_R4: assert property (@(posedge clk) disable iff (rst)
      (srcAddr[g] == '0) |-> (fwdSel[g] == FWD_NONE && !strobe.loadUseSrc[g]));

    assert_sel_legal_R3: assert property (@(posedge clk) disable iff (rst)
      fwdSel[g] != 2'd3);
  end

  assign strobe.loadUseSrc = loadUseVec;

endmodule

// File: rtl/hazard_stall_ctrl.sv
module hazard_stall_ctrl
  import hazard_stall_pkg::*;
#(
  parameter int BR_PENALTY = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  hazStrobe_t strobe,
  input  logic       brTaken,
  input  logic       brDelaySlot,
  input  logic       execBusy,
  input  logic       memReq,
  input  logic       memReady,
  output logic       stallFetch,
  output logic       stallDecode,
  output logic       stallExecute,
  output logic       stallMemory,
  output logic       bubbleExecute,
  output logic       bubbleMemory,
  output logic       bubbleWriteback,
  output logic       fetchBubble
);

  localparam int CNT_W = $clog2(BR_PENALTY + 1);
  localparam logic [CNT_W-1:0] PEN_FULL = CNT_W'(BR_PENALTY);
  localparam logic [CNT_W-1:0] PEN_SLOT = CNT_W'(BR_PENALTY - 1);

  logic [CNT_W-1:0] brCnt;
  logic             brPending;
  logic             memWait;
  logic             loadUse;

  // branch penalty runs independently of other stalls so overlaps merge
  always_ff @(posedge clk) begin
    if (rst)               brCnt <= '0;
    else if (brTaken)      brCnt <= brDelaySlot ? PEN_SLOT : PEN_FULL;
    else if (brCnt != '0)  brCnt <= brCnt - CNT_W'(1);
  end

  assign brPending = (brCnt != '0);
  assign memWait   = memReq & ~memReady;
  assign loadUse   = |strobe.loadUseSrc;

  always_comb begin
    stallMemory     = memWait;
    stallExecute    = memWait | execBusy;
    stallDecode     = stallExecute | loadUse;
    stallFetch      = stallDecode | brPending;
    bubbleWriteback = memWait;
    bubbleMemory    = execBusy & ~memWait;
    bubbleExecute   = loadUse & ~stallExecute;
    fetchBubble     = brPending & ~stallDecode;
  end

  assert_stall_nest_R11: assert property (@(posedge clk) disable iff (rst)
    (!stallMemory || stallExecute) && (!stallExecute || stallDecode) &&
    (!stallDecode || stallFetch));

  assert_one_bubble_R11: assert property (@(posedge clk) disable iff (rst)
    $onehot0({bubbleExecute, bubbleMemory, bubbleWriteback, fetchBubble}));

  assert_mem_wait_R7: assert property (@(posedge clk) disable iff (rst)
    (memReq && !memReady) |-> (stallMemory && stallFetch && bubbleWriteback && !bubbleMemory));

  assert_exec_busy_R6: assert property (@(posedge clk) disable iff (rst)
    execBusy |-> (stallExecute && !bubbleExecute));

  assert_load_use_R5: assert property (@(posedge clk) disable iff (rst)
    (|strobe.loadUseSrc) |-> (stallDecode && stallFetch));

  assert_branch_stall_R8: assert property (@(posedge clk) disable iff (rst)
    (brTaken && (!brDelaySlot || BR_PENALTY > 1)) |=> stallFetch);

endmodule

// File: rtl/hazard_stall_unit.sv
module hazard_stall_unit
  import hazard_stall_pkg::*;
#(
  parameter int REG_ADDR_W = 5,
  parameter int BR_PENALTY = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [REG_ADDR_W-1:0] decRs1,
  input  logic [REG_ADDR_W-1:0] decRs2,
  input  logic                  decUseRs1,
  input  logic                  decUseRs2,
  input  logic [REG_ADDR_W-1:0] exRd,
  input  logic                  exWe,
  input  logic                  exIsLoad,
  input  logic                  exValid,
  input  logic [REG_ADDR_W-1:0] memRd,
  input  logic                  memWe,
  input  logic                  memValid,
  input  logic                  brTaken,
  input  logic                  brDelaySlot,
  input  logic                  execBusy,
  input  logic                  memReq,
  input  logic                  memReady,
  output logic                  stallFetch,
  output logic                  stallDecode,
  output logic                  stallExecute,
  output logic                  stallMemory,
  output logic                  bubbleExecute,
  output logic                  bubbleMemory,
  output logic                  bubbleWriteback,
  output logic                  fetchBubble,
  output logic [1:0]            fwdSelA,
  output logic [1:0]            fwdSelB
);

  logic [NUM_SRC-1:0][REG_ADDR_W-1:0] srcAddr;
  logic [NUM_SRC-1:0]                 srcUsed;
  logic [NUM_SRC-1:0][1:0]            fwdSel;
  hazStrobe_t                         strobe;

  assign srcAddr = {decRs2, decRs1};
  assign srcUsed = {decUseRs2, decUseRs1};
  assign fwdSelA = fwdSel[0];
  assign fwdSelB = fwdSel[1];

  hazard_operand_cmp #(.REG_ADDR_W(REG_ADDR_W)) uCmp (
    .clk(clk), .rst(rst),
    .srcAddr(srcAddr), .srcUsed(srcUsed),
    .exRd(exRd), .exWe(exWe), .exIsLoad(exIsLoad), .exValid(exValid),
    .memRd(memRd), .memWe(memWe), .memValid(memValid),
    .fwdSel(fwdSel), .strobe(strobe)
  );

  hazard_stall_ctrl #(.BR_PENALTY(BR_PENALTY)) uCtrl (
    .clk(clk), .rst(rst), .strobe(strobe),
    .brTaken(brTaken), .brDelaySlot(brDelaySlot),
    .execBusy(execBusy), .memReq(memReq), .memReady(memReady),
    .stallFetch(stallFetch), .stallDecode(stallDecode),
    .stallExecute(stallExecute), .stallMemory(stallMemory),
    .bubbleExecute(bubbleExecute), .bubbleMemory(bubbleMemory),
    .bubbleWriteback(bubbleWriteback), .fetchBubble(fetchBubble)
  );

endmodule

// File: tb/hazard_stall_unit_test.sv
module hazard_stall_unit_test;

  localparam int CLK_PERIOD = 10;
  localparam int AW  = 2;
  localparam int PEN = 3;

  logic clk = 1'b0;
  logic rst;
  logic [AW-1:0] decRs1, decRs2, exRd, memRd;
  logic decUseRs1, decUseRs2, exWe, exIsLoad, exValid, memWe, memValid;
  logic brTaken, brDelaySlot, execBusy, memReq, memReady;
  logic stallFetch, stallDecode, stallExecute, stallMemory;
  logic bubbleExecute, bubbleMemory, bubbleWriteback, fetchBubble;
  logic [1:0] fwdSelA, fwdSelB;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hazard_stall_unit #(.REG_ADDR_W(AW), .BR_PENALTY(PEN)) uut (
    .clk(clk), .rst(rst),
    .decRs1(decRs1), .decRs2(decRs2), .decUseRs1(decUseRs1), .decUseRs2(decUseRs2),
    .exRd(exRd), .exWe(exWe), .exIsLoad(exIsLoad), .exValid(exValid),
    .memRd(memRd), .memWe(memWe), .memValid(memValid),
    .brTaken(brTaken), .brDelaySlot(brDelaySlot),
    .execBusy(execBusy), .memReq(memReq), .memReady(memReady),
    .stallFetch(stallFetch), .stallDecode(stallDecode),
    .stallExecute(stallExecute), .stallMemory(stallMemory),
    .bubbleExecute(bubbleExecute), .bubbleMemory(bubbleMemory),
    .bubbleWriteback(bubbleWriteback), .fetchBubble(fetchBubble),
    .fwdSelA(fwdSelA), .fwdSelB(fwdSelB)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle();
    decRs1 = '0; decRs2 = '0; decUseRs1 = 0; decUseRs2 = 0;
    exRd = '0; exWe = 0; exIsLoad = 0; exValid = 0;
    memRd = '0; memWe = 0; memValid = 0;
    brTaken = 0; brDelaySlot = 0; execBusy = 0; memReq = 0; memReady = 0;
  endtask

  function automatic int expSel(input int rs, input int eRd, input int eP,
                                input int mRd, input int mP);
    if (rs != 0 && eP != 0 && eRd == rs) return 1;
    if (rs != 0 && mP != 0 && mRd == rs) return 2;
    return 0;
  endfunction

  function automatic string selTag(input int rs, input int sel);
    if (rs == 0) return "R4";
    if (sel == 1) return "R2";
    return "R3";
  endfunction

  // branch followed by a stall of n cycles from execBusy (kind 1) or memory wait (kind 0)
  task automatic runBranch(input int slot, input int n, input int kind);
    int sfCount = 0;
    int fbCount = 0;
    int p = PEN - slot;
    int expSf = (n > p) ? n : p;
    int expFb = (p > n) ? p - n : 0;
    string tag = (n == 0) ? ((slot != 0) ? "R9" : "R8") : "R10";
    @(negedge clk);
    idle();
    brTaken = 1; brDelaySlot = slot[0];
    #1;
    check("R8 no fetch stall in strobe cycle", int'(stallFetch), 0);
    @(negedge clk);
    brTaken = 0; brDelaySlot = 0;
    for (int k = 0; k < 8; k++) begin
      if (kind == 0) memReq = (k < n);
      else           execBusy = (k < n);
      #1;
      sfCount += int'(stallFetch);
      fbCount += int'(fetchBubble);
      @(negedge clk);
    end
    idle();
    check({tag, " stallFetch cycles"}, sfCount, expSf);
    check({tag, " fetchBubble cycles"}, fbCount, expFb);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle();
    rst = 1;
    brTaken = 1;   // strobe during reset must leave no pending penalty
    repeat (3) @(negedge clk);
    idle();
    rst = 0;
    @(negedge clk);
    #1;
    // R1: quiet reset state
    check("R1 stallFetch", int'(stallFetch), 0);
    check("R1 stallDecode", int'(stallDecode), 0);
    check("R1 stallExecute", int'(stallExecute), 0);
    check("R1 stallMemory", int'(stallMemory), 0);
    check("R1 bubbles", int'({bubbleExecute, bubbleMemory, bubbleWriteback, fetchBubble}), 0);
    check("R1 fwdSelA", int'(fwdSelA), 0);
    check("R1 fwdSelB", int'(fwdSelB), 0);

    // R2 R3 R4 R5: exhaustive operand sweep
    for (int v = 0; v < (1 << 15); v++) begin
      logic [14:0] bits;
      int eP, mP, lu, sA, sB;
      bits = 15'(v);
      decRs1 = bits[1:0]; decRs2 = bits[3:2];
      exRd = bits[5:4]; memRd = bits[7:6];
      exWe = bits[8]; exValid = bits[9]; exIsLoad = bits[10];
      memWe = bits[11]; memValid = bits[12];
      decUseRs1 = bits[13]; decUseRs2 = bits[14];
      #1;
      eP = int'(exWe & exValid);
      mP = int'(memWe & memValid);
      sA = expSel(int'(decRs1), int'(exRd), eP, int'(memRd), mP);
      sB = expSel(int'(decRs2), int'(exRd), eP, int'(memRd), mP);
      lu = ((sA == 1 && decUseRs1) || (sB == 1 && decUseRs2)) && exIsLoad ? 1 : 0;
      check({selTag(int'(decRs1), sA), " fwdSelA"}, int'(fwdSelA), sA);
      check({selTag(int'(decRs2), sB), " fwdSelB"}, int'(fwdSelB), sB);
      check("R5 stallDecode on load-use", int'(stallDecode), lu);
      check("R5 bubbleExecute on load-use", int'(bubbleExecute), lu);
      check("R5 stallFetch on load-use", int'(stallFetch), lu);
      check("R5 execute not held", int'(stallExecute), 0);
    end
    idle();

    // R5 R6 R7 R11: structural hazard mixes
    for (int m = 0; m < 16; m++) begin
      int lu, eb, mq, mr, mw, sEx, sDec;
      lu = (m >> 3) & 1; eb = (m >> 2) & 1; mq = (m >> 1) & 1; mr = m & 1;
      idle();
      if (lu != 0) begin
        decRs1 = 2'd1; decUseRs1 = 1; exRd = 2'd1;
        exValid = 1; exWe = 1; exIsLoad = 1;
      end
      execBusy = eb[0]; memReq = mq[0]; memReady = mr[0];
      #1;
      mw = mq & (1 - mr);
      sEx = (mw | eb);
      sDec = (sEx | lu);
      check("R7 stallMemory", int'(stallMemory), mw);
      check("R6 stallExecute", int'(stallExecute), sEx);
      check("R5 stallDecode", int'(stallDecode), sDec);
      check("R11 stallFetch", int'(stallFetch), sDec);
      check("R7 bubbleWriteback", int'(bubbleWriteback), mw);
      check("R6 bubbleMemory", int'(bubbleMemory), (eb != 0 && mw == 0) ? 1 : 0);
      check("R5 bubbleExecute", int'(bubbleExecute), (lu != 0 && sEx == 0) ? 1 : 0);
      check("R11 fetchBubble", int'(fetchBubble), 0);
      #4;
    end
    idle();

    // R8 R9 R10: branch penalty alone and overlapped
    for (int slot = 0; slot < 2; slot++)
      for (int n = 0; n < 5; n++)
        for (int kind = 0; kind < 2; kind++)
          runBranch(slot, n, kind);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule